// File: doc/BRIEF.md
# TLB Special-Register Access Unit

This block is the register front end of a software-managed MMU. The processor reaches it with move-to and move-from special-register operations. Each operation presents its immediate field and, for writes, a 32-bit data word. The unit decodes the special-register number and works out whether the operation belongs to the MMU group. It then reads or writes one of its registers: the entry index, the process ID, or one of two 64-bit TLB banks. A third, per-entry tag array holds the process ID recorded for each entry.

A TLB word is 64 bits wide, but each access moves 32 bits. The extended-access bit in the immediate selects the upper half of the word. It is legal only for the low TLB register. An access to the high TLB register also moves the process ID: a read copies the entry's stored tag into the process-ID register, and a write stores the process ID as the entry's tag. A write to the high register also produces a one-cycle flush pulse that names the rewritten entry, so that cached translations for that entry can be dropped.

Read data is registered and appears one cycle after the request. A configuration parameter can build the MMU as absent. The unit then answers every read with zero and ignores every write.

Top module: `tlb_sreg_unit`

## Requirements
- R1: A request belongs to the MMU group only when immediate bits 13:8 equal 0x10. Bits 7:3 are ignored, bits 2:0 pick the register, and immediate bit 14 set means write. A request outside the group changes no state and produces no read-valid pulse.
- R2: A read in the group raises rd_valid for exactly the following cycle, with the value in rd_data. The register codes are 0 (process ID, 8 bits stored, read back zero-extended), 2 (entry index, all 32 bits stored and read back), 3 (TLB low) and 4 (TLB high). Codes 1, 5, 6 and 7 read as 0 and ignore writes.
- R3: For a write the extended bit is immediate bit 24, and for a read it is immediate bit 19. The bit at the other position has no effect. When ADDR_SIZE is 32 or less, the extended bit is forced to 0.
- R4: The TLB entry is chosen by bits 7:0 of the index register (256 entries). Register 4 reaches bank 0 and register 3 reaches bank 1. Every bank entry is a separate 64-bit word.
- R5: An access with the extended bit set reaches bits 63:32 of the entry, and one with it clear reaches bits 31:0. A write replaces only that half and leaves the other half as it was.
- R6: An extended access to any register other than code 3 is rejected. A read returns 0 (still with rd_valid), and a write changes nothing and raises no flush.
- R7: A read of register 4 also loads the process-ID register with the tag stored for the indexed entry.
- R8: A write to register 4 stores the low 8 bits of the process-ID register as the indexed entry's tag. It also drives flush_valid high for exactly the next cycle, with flush_index equal to the entry index.
- R9: With MMU_PRESENT set to 0, every group read returns 0 with rd_valid, every write is ignored, and flush_valid never rises.
- R10: Synchronous reset clears the index and process-ID registers, all tags, rd_valid and flush_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A special-register operation is presented this cycle |
| req_imm | input | 25 | Immediate field of the operation (register number, direction, extended bit) |
| req_wdata | input | 32 | Data for a write operation |
| rd_valid | output | 1 | rd_data holds the result of the previous cycle's group read |
| rd_data | output | 32 | Registered read result |
| flush_valid | output | 1 | One-cycle pulse after a high-register write |
| flush_index | output | 8 | Entry index to flush while flush_valid is high |

## Verification
The embedded properties watch timing and legality on every cycle. Each rd_valid must trace back to a group read one cycle earlier, and each flush pulse to a high-register write. A rejected extended read must return zero, reset must leave both pulses low, and an absent MMU must stay silent. Data content is shown only by the bench's sweeps. These cover half-word independence across all 256 entries of both banks, the tag moving into the process ID on high reads, and the extended-bit position that depends on direction. The same stimulus also drives a narrow-address build and an absent build, so that forcing the extended bit to zero and the silent mode are compared against the full build.

// File: rtl/tlb_sreg_pkg.sv
package tlb_sreg_pkg;

    localparam int IMM_W    = 25;
    localparam int DATA_W   = 32;
    localparam int TAG_W    = 8;
    localparam int WORD_W   = 2 * DATA_W;
    localparam int SEL_LSB  = 8;
    localparam int SEL_MSB  = 13;
    localparam int DIR_BIT  = 14;
    localparam int EXT_WR_BIT = 24;
    localparam int EXT_RD_BIT = 19;
    localparam logic [SEL_MSB-SEL_LSB:0] GROUP_CODE = 6'h10;

    typedef enum logic [2:0] {
        SR_PID    = 3'd0,
        SR_ZONE   = 3'd1,
        SR_INDEX  = 3'd2,
        SR_LOW    = 3'd3,
        SR_HIGH   = 3'd4,
        SR_SEARCH = 3'd5,
        SR_RSV6   = 3'd6,
        SR_RSV7   = 3'd7
    } sreg_e;

    typedef struct packed {
        logic  hit;
        logic  wr;
        logic  ext;
        sreg_e sel;
    } sreg_req_t;

    function automatic logic ext_legal(sreg_req_t r);
        return !r.ext || (r.sel == SR_LOW);
    endfunction

    function automatic logic is_tlb_reg(sreg_e s);
        return (s == SR_LOW) || (s == SR_HIGH);
    endfunction

    function automatic logic bank_of(sreg_e s);
        return s[0];
    endfunction

endpackage

// File: rtl/tlb_sreg_decode.sv
module tlb_sreg_decode
    import tlb_sreg_pkg::*;
#(
    parameter int ADDR_SIZE = 64
) (
    input  logic             valid,
    input  logic [IMM_W-1:0] imm,
    output sreg_req_t        req
);
    logic wr;
    logic ext_raw;

    assign wr      = imm[DIR_BIT];
    assign ext_raw = wr ? imm[EXT_WR_BIT] : imm[EXT_RD_BIT];

    always_comb begin
        req.hit = valid && (imm[SEL_MSB:SEL_LSB] == GROUP_CODE);
        req.wr  = wr;
        req.sel = sreg_e'(imm[2:0]);
    end

    generate
        if (ADDR_SIZE > 32) begin : g_wide
            assign req.ext = ext_raw;
        end else begin : g_narrow
            assign req.ext = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_sreg_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              bank,
    input  logic              upper,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int BANKS   = 2;

    logic [WORD_W-1:0] word [BANKS];

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            logic [WORD_W-1:0] mem [ENTRIES];
            always_ff @(posedge clk) begin
                if (we && (bank == 1'(b))) begin
                    if (upper)
                        mem[idx][WORD_W-1:DATA_W] <= wdata;
                    else
                        mem[idx][DATA_W-1:0] <= wdata;
                end
            end
            assign word[b] = mem[idx];
        end
    endgenerate

    always_comb begin
        if (upper)
            rdata = word[bank][WORD_W-1:DATA_W];
        else
            rdata = word[bank][DATA_W-1:0];
    end
endmodule

// File: rtl/tlb_tag_array.sv
module tlb_tag_array
    import tlb_sreg_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] wtag,
    output logic [TAG_W-1:0] rtag
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [TAG_W-1:0] tags [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tags[i] <= '0;
        end else if (we) begin
            tags[idx] <= wtag;
        end
    end

    assign rtag = tags[idx];
endmodule

// File: rtl/tlb_sreg_unit.sv
module tlb_sreg_unit
    import tlb_sreg_pkg::*;
#(
    parameter int ADDR_SIZE   = 64,
    parameter int MMU_PRESENT = 1,
    parameter int IDX_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [24:0]       req_imm,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              flush_valid,
    output logic [IDX_W-1:0]  flush_index
);
    localparam bit ON = (MMU_PRESENT != 0);

    sreg_req_t         req;
    logic              acc;
    logic              ram_we;
    logic              tag_we;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] ram_rdata;
    logic [TAG_W-1:0]  tag_rdata;
    logic [DATA_W-1:0] rd_mux;

    logic [DATA_W-1:0] index_q;
    logic [TAG_W-1:0]  pid_q;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              flush_q;
    logic [IDX_W-1:0]  flush_idx_q;

    tlb_sreg_decode #(.ADDR_SIZE(ADDR_SIZE)) u_decode (
        .valid (req_valid),
        .imm   (req_imm),
        .req   (req)
    );

    assign acc    = ON && req.hit && ext_legal(req);
    assign idx    = index_q[IDX_W-1:0];
    assign ram_we = acc && req.wr && is_tlb_reg(req.sel);
    assign tag_we = acc && req.wr && (req.sel == SR_HIGH);

    tlb_entry_store #(.IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .we    (ram_we),
        .bank  (bank_of(req.sel)),
        .upper (req.ext),
        .idx   (idx),
        .wdata (req_wdata),
        .rdata (ram_rdata)
    );

    tlb_tag_array #(.IDX_W(IDX_W)) u_tags (
        .clk  (clk),
        .rst  (rst),
        .we   (tag_we),
        .idx  (idx),
        .wtag (pid_q),
        .rtag (tag_rdata)
    );

    always_comb begin
        rd_mux = '0;
        if (acc) begin
            case (req.sel)
                SR_PID:          rd_mux = {{(DATA_W-TAG_W){1'b0}}, pid_q};
                SR_INDEX:        rd_mux = index_q;
                SR_LOW, SR_HIGH: rd_mux = ram_rdata;
                default:         rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q     <= '0;
            pid_q       <= '0;
            rd_valid_q  <= 1'b0;
            rd_data_q   <= '0;
            flush_q     <= 1'b0;
            flush_idx_q <= '0;
        end else begin
            rd_valid_q  <= req.hit && !req.wr;
            flush_q     <= tag_we;
            flush_idx_q <= idx;
            if (req.hit && !req.wr)
                rd_data_q <= rd_mux;
            if (acc && req.wr) begin
                if (req.sel == SR_PID)   pid_q   <= req_wdata[TAG_W-1:0];
                if (req.sel == SR_INDEX) index_q <= req_wdata;
            end else if (acc && (req.sel == SR_HIGH)) begin
                pid_q <= tag_rdata;
            end
        end
    end

    assign rd_valid    = rd_valid_q;
    assign rd_data     = rd_data_q;
    assign flush_valid = flush_q;
    assign flush_index = flush_idx_q;

    // R2: a read-valid pulse always traces back to a group read one cycle earlier
    a_r2_rd_valid_source: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(req_valid && !req_imm[DIR_BIT]
                           && req_imm[SEL_MSB:SEL_LSB] == GROUP_CODE));

    // R8: a flush pulse always traces back to a write of register 4
    a_r8_flush_source: assert property (@(posedge clk) disable iff (rst)
        flush_valid |-> $past(req_valid && req_imm[DIR_BIT]
                              && req_imm[SEL_MSB:SEL_LSB] == GROUP_CODE
                              && req_imm[2:0] == 3'd4));

    // R10: the cycle after reset shows no pulses
    a_r10_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!rd_valid && !flush_valid));

    generate
        if (ADDR_SIZE > 32) begin : g_ext_chk
            // R6: an extended read of anything but register 3 returns zero
            a_r6_ext_read_zero: assert property (@(posedge clk) disable iff (rst)
                ($past(req_valid && !req_imm[DIR_BIT] && req_imm[EXT_RD_BIT]
                       && req_imm[SEL_MSB:SEL_LSB] == GROUP_CODE
                       && req_imm[2:0] != 3'd3) && rd_valid) |-> (rd_data == '0));
        end
        if (!ON) begin : g_absent_chk
            // R9: an absent MMU reads zero and never flushes
            a_r9_absent_silent: assert property (@(posedge clk) disable iff (rst)
                (rd_valid |-> rd_data == '0) and !flush_valid);
        end
    endgenerate
endmodule

// File: tb/tlb_sreg_unit_bench.sv
module tlb_sreg_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [24:0] req_imm = '0;
    logic [31:0] req_wdata = '0;

    logic        m_rv, n_rv, a_rv;
    logic [31:0] m_rd, n_rd, a_rd;
    logic        m_fl, n_fl, a_fl;
    logic [7:0]  m_fi, n_fi, a_fi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tlb_sreg_unit #(.ADDR_SIZE(64), .MMU_PRESENT(1)) u_tlb_sreg_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_imm(req_imm), .req_wdata(req_wdata),
        .rd_valid(m_rv), .rd_data(m_rd), .flush_valid(m_fl), .flush_index(m_fi));

    tlb_sreg_unit #(.ADDR_SIZE(32), .MMU_PRESENT(1)) u_narrow (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_imm(req_imm), .req_wdata(req_wdata),
        .rd_valid(n_rv), .rd_data(n_rd), .flush_valid(n_fl), .flush_index(n_fi));

    tlb_sreg_unit #(.ADDR_SIZE(64), .MMU_PRESENT(0)) u_absent (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_imm(req_imm), .req_wdata(req_wdata),
        .rd_valid(a_rv), .rd_data(a_rd), .flush_valid(a_fl), .flush_index(a_fi));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [24:0] mk_imm(input bit wr, input bit ext, input logic [2:0] rn);
        logic [24:0] v = '0;
        v[13:0] = 14'h1000 | 14'(rn);
        v[14]   = wr;
        if (ext) begin
            if (wr) v[24] = 1'b1;
            else    v[19] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [31:0] pat(input int i, input int k);
        return {8'(k * 37 + 5), 8'(i), ~8'(i), 8'(i ^ k)};
    endfunction

    task automatic raw(input logic [24:0] imm, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_imm   = imm;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic op(input bit wr, input bit ext, input logic [2:0] rn, input logic [31:0] wd);
        raw(mk_imm(wr, ext, rn), wd);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 rd_valid after reset", 32'(m_rv), 0);
        chk("R10 flush after reset", 32'(m_fl), 0);
        op(0, 0, 3'd0, 0);
        chk("R10 pid reset", m_rd, 0);
        op(0, 0, 3'd2, 0);
        chk("R10 index reset", m_rd, 0);
        op(1, 0, 3'd0, 32'h33);
        op(0, 0, 3'd4, 0);
        op(0, 0, 3'd0, 0);
        chk("R10 R7 tag reset loads pid 0", m_rd, 0);

        // pass 1: fill every entry
        for (int i = 0; i < 256; i++) begin
            op(1, 0, 3'd2, {8'hC3, 8'(i * 3), 8'h11, 8'(i)});
            op(1, 0, 3'd0, 32'hFFFF_FF5A ^ 32'(i));
            op(1, 0, 3'd4, pat(i, 1));
            chk("R8 flush pulse", 32'(m_fl), 1);
            chk("R8 flush index", 32'(m_fi), 32'(i));
            chk("R9 absent no flush", 32'(a_fl), 0);
            op(1, 1, 3'd3, pat(i, 3));
            chk("R8 flush one cycle", 32'(m_fl), 0);
            op(1, 0, 3'd3, pat(i, 2));
            if (i % 16 == 0) begin
                op(1, 1, 3'd4, 32'hDEAD);
                chk("R6 ext high write no flush", 32'(m_fl), 0);
                chk("R3 narrow ext forced off flushes", 32'(n_fl), 1);
            end
        end

        // pass 2: read back every entry
        for (int i = 0; i < 256; i++) begin
            op(1, 0, 3'd2, 32'(i));
            op(1, 0, 3'd0, 0);
            op(0, 0, 3'd4, 0);
            chk("R4 high bank low half", m_rd, pat(i, 1));
            chk("R9 absent read zero", a_rd, 0);
            chk("R9 absent read valid", 32'(a_rv), 1);
            chk("R3 narrow high", n_rd, (i % 16 == 0) ? 32'hDEAD : pat(i, 1));
            op(0, 0, 3'd0, 0);
            chk("R7 pid from tag", m_rd, 32'((i ^ 32'h5A) & 32'hFF));
            op(0, 0, 3'd3, 0);
            chk("R5 low bank low half", m_rd, pat(i, 2));
            op(0, 1, 3'd3, 0);
            chk("R5 low bank upper half", m_rd, pat(i, 3));
            chk("R3 narrow ext read gives low half", n_rd, pat(i, 2));
            op(0, 1, 3'd4, 0);
            chk("R6 ext high read zero", m_rd, 0);
            chk("R6 ext high read valid", 32'(m_rv), 1);
        end

        // R5: rewrite low half keeps upper half
        op(1, 0, 3'd2, 32'd7);
        op(1, 0, 3'd3, 32'h1234_5678);
        op(0, 1, 3'd3, 0);
        chk("R5 upper kept after low write", m_rd, pat(7, 3));
        op(0, 0, 3'd3, 0);
        chk("R5 low replaced", m_rd, 32'h1234_5678);

        // R3: ext bit position depends on direction
        raw(mk_imm(1, 0, 3'd3) | 25'(1 << 19), 32'hAAAA_0001);
        op(0, 1, 3'd3, 0);
        chk("R3 write bit19 not extended", m_rd, pat(7, 3));
        raw(mk_imm(0, 0, 3'd3) | 25'(1 << 24), 0);
        chk("R3 read bit24 not extended", m_rd, 32'hAAAA_0001);

        // R2: index full width, unused codes zero
        op(1, 0, 3'd2, 32'hA5C3_0F07);
        op(0, 0, 3'd2, 0);
        chk("R2 index full width", m_rd, 32'hA5C3_0F07);
        op(1, 0, 3'd0, 32'h1234_56F0);
        op(0, 0, 3'd0, 0);
        chk("R2 pid zero-extended", m_rd, 32'hF0);
        for (int c = 1; c < 8; c++) begin
            if (c == 1 || c >= 5) begin
                op(1, 0, 3'(c), 32'hFFFF_FFFF);
                op(0, 0, 3'(c), 0);
                chk("R2 unused code reads zero", m_rd, 0);
                op(0, 0, 3'd2, 0);
                chk("R2 unused write leaves index", m_rd, 32'hA5C3_0F07);
            end
        end

        // R1: group decode
        raw(25'h0_4002, 32'h99);
        raw(25'h0_5102, 32'h98);
        op(0, 0, 3'd2, 0);
        chk("R1 out-of-group writes ignored", m_rd, 32'hA5C3_0F07);
        raw(25'h0_50FA, 32'h0000_0042);
        op(0, 0, 3'd2, 0);
        chk("R1 bits 7:3 ignored", m_rd, 32'h42);
        raw(25'h0_0002, 0);
        chk("R1 out-of-group read no valid", 32'(m_rv), 0);

        // R9: absent ignores writes
        op(1, 0, 3'd0, 32'h77);
        op(0, 0, 3'd0, 0);
        chk("R9 absent pid read zero", a_rd, 0);
        chk("R2 pid readback", m_rd, 32'h77);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule